// File: doc/BRIEF.md
# Data memory with indirect windows

This block is the byte-wide data memory of a small 8-bit controller core. Its 256 addresses mix a special-register region at the bottom with general-purpose RAM at the top. The core uses one byte port for reads and writes and one single-bit port to set or clear a bit. The accumulator and the status register live in the special region like any other location. Their current values are also driven out as ports, so the core does not need an extra read cycle to see them.

Two addresses have no storage of their own. Each one is a window that forwards the access to the location held in a pointer register that sits next to it. A pointer may aim at any of the 256 addresses. When a pointer aims at one of the windows, reads return zero and writes are dropped. The gap between the last special register and the start of RAM is reserved. It reads as zero and ignores writes. Two status bits are owned by hardware: they follow a flag input and cannot be changed through either port. Peripheral slots in the special region are plain storage here.

Top module: `dmem_window`

## Requirements
- R1: A byte write with `wr_en` high stores `wdata` at a backed address on the rising edge. Backed addresses are 01H, 03H..28H and 40H..FFH. `rdata` returns the stored byte combinationally in the same cycle that `addr` selects it.
- R2: An access at 00H reads or writes the location whose address is held in the pointer at 01H. An access at 02H does the same through the pointer at 03H. Both pointers are full 8-bit registers.
- R3: When the selected pointer holds 00H or 02H, a read through the window returns 00H and a write through it changes no location.
- R4: Addresses 29H..3FH read as 00H, and byte writes or bit operations aimed at them have no effect.
- R5: The accumulator is location 05H and the status register is location 0AH. `acc_q` and `stat_q` always show their stored values.
- R6: With `bit_en` high, bit `bit_idx` (0 = LSB) of the location resolved from `bit_addr` becomes `bit_val` (1 = set, 0 = clear) at the rising edge. The other seven bits stay unchanged. Windows resolve the same way as for byte accesses.
- R7: Status bits 5:4 are protected. On every clock edge they load `hw_flags[1:0]`, and neither port can change them.
- R8: When a byte write and a bit operation resolve to the same location in one cycle, the bit operation is applied on top of the newly written byte.
- R9: After reset both pointers, the accumulator, the status register and every other special location read 00H. RAM contents stay undefined until they are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Byte port address (read and write) |
| wdata | input | 8 | Byte write data |
| rdata | output | 8 | Byte read data, combinational |
| bit_en | input | 1 | Bit operation strobe |
| bit_addr | input | 8 | Bit port address |
| bit_idx | input | 3 | Bit position, 0 = LSB |
| bit_val | input | 1 | 1 sets the bit, 0 clears it |
| hw_flags | input | 2 | Values loaded into status bits 5:4 each cycle |
| acc_q | output | 8 | Current accumulator value |
| stat_q | output | 8 | Current status register value |

## Verification
A byte write and a bit operation can fall in the same cycle. They can hit the same location, either directly or when one goes through a window and the other names the target address. One case is the bench writing the accumulator while it sets a bit of the accumulator through a pointer. The bench also drives random mixes of both ports with addresses biased toward the windows, the pointers, the accumulator, the status slot and a small group of RAM bytes, so collisions happen often. A behavioural model applies the byte first and the bit second, and every clock it is compared with `rdata`, `acc_q` and `stat_q`. This shows the merge order and the fact that a pointer rewritten in a cycle only takes effect from the next cycle.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  typedef logic [AW-1:0] addr_t;
  typedef logic [DW-1:0] byte_t;

  localparam addr_t WIN0     = 8'h00;
  localparam addr_t PTR0     = 8'h01;
  localparam addr_t WIN1     = 8'h02;
  localparam addr_t PTR1     = 8'h03;
  localparam addr_t ACC_LOC  = 8'h05;
  localparam addr_t STAT_LOC = 8'h0A;
  localparam addr_t SFR_LAST = 8'h28;
  localparam addr_t RAM_FIRST = 8'h40;
  localparam addr_t ADDR_MAX = 8'hFF;
  localparam int    FLAG_LSB = 4;
  localparam int    FLAG_W   = 2;
endpackage

// File: rtl/dmem_resolve.sv
module dmem_resolve
  import dmem_pkg::*;
#(
  parameter addr_t TOP  = SFR_LAST,
  parameter addr_t BASE = RAM_FIRST
) (
  input  addr_t addr,
  input  addr_t mp0,
  input  addr_t mp1,
  output addr_t tgt,
  output logic  ok
);
  logic is_null;
  logic backed;

  always_comb begin
    unique case (addr)
      WIN0:    tgt = mp0;
      WIN1:    tgt = mp1;
      default: tgt = addr;
    endcase
    is_null = (tgt == WIN0) || (tgt == WIN1);
    backed  = (tgt <= TOP) || (tgt >= BASE);
    ok      = backed && !is_null;
  end
endmodule

// File: rtl/dmem_store.sv
module dmem_store
  import dmem_pkg::*;
#(
  parameter addr_t TOP  = SFR_LAST,
  parameter addr_t BASE = RAM_FIRST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_we,
  input  addr_t             a_tgt,
  input  logic              a_ok,
  input  byte_t             a_wd,
  input  logic              b_we,
  input  addr_t             b_tgt,
  input  logic [2:0]        b_idx,
  input  logic              b_set,
  input  logic [FLAG_W-1:0] flags,
  output byte_t             rdata,
  output addr_t             mp0,
  output addr_t             mp1,
  output byte_t             acc,
  output byte_t             stat
);
  localparam int SW     = $clog2(int'(TOP) + 1);
  localparam int NSLOTS = int'(TOP) + 1;

  byte_t sfr_q [NSLOTS];
  byte_t sfr_d [NSLOTS];
  byte_t ram_q [BASE:ADDR_MAX];

  byte_t b_cur, b_base, b_data, a_data;
  logic  same_loc;
  logic  ram_a_we, ram_b_we;

  function automatic byte_t peek(addr_t t);
    if (t >= BASE)     return ram_q[t];
    else if (t <= TOP) return sfr_q[t[SW-1:0]];
    else               return '0;
  endfunction

  // merge of the two write sources: byte first, bit on top
  always_comb begin
    same_loc = a_we && b_we && (a_tgt == b_tgt);
    b_cur    = peek(b_tgt);
    b_base   = same_loc ? a_wd : b_cur;
    b_data   = b_base;
    b_data[b_idx] = b_set;
    a_data   = same_loc ? b_data : a_wd;
  end

  // special-register next state
  always_comb begin
    for (int i = 0; i < NSLOTS; i++) begin
      sfr_d[i] = sfr_q[i];
      if (a_we && a_tgt == addr_t'(i)) sfr_d[i] = a_data;
      if (b_we && b_tgt == addr_t'(i)) sfr_d[i] = b_data;
      if (addr_t'(i) == STAT_LOC) sfr_d[i][FLAG_LSB +: FLAG_W] = flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) sfr_q[i] <= '0;
    end else begin
      for (int i = 0; i < NSLOTS; i++) sfr_q[i] <= sfr_d[i];
    end
  end

  // general-purpose RAM, no reset
  always_comb begin
    ram_a_we = a_we && (a_tgt >= BASE);
    ram_b_we = b_we && (b_tgt >= BASE);
  end

  always_ff @(posedge clk) begin
    if (ram_a_we) ram_q[a_tgt] <= a_data;
    if (ram_b_we) ram_q[b_tgt] <= b_data;
  end

  always_comb begin
    rdata = a_ok ? peek(a_tgt) : '0;
    mp0   = sfr_q[PTR0[SW-1:0]];
    mp1   = sfr_q[PTR1[SW-1:0]];
    acc   = sfr_q[ACC_LOC[SW-1:0]];
    stat  = sfr_q[STAT_LOC[SW-1:0]];
  end
endmodule

// File: rtl/dmem_window.sv
module dmem_window
  import dmem_pkg::*;
#(
  parameter addr_t TOP  = SFR_LAST,
  parameter addr_t BASE = RAM_FIRST
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       bit_en,
  input  logic [7:0] bit_addr,
  input  logic [2:0] bit_idx,
  input  logic       bit_val,
  input  logic [1:0] hw_flags,
  output logic [7:0] acc_q,
  output logic [7:0] stat_q
);
  logic [1:0] rst_sync;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  addr_t mp0, mp1, a_tgt, b_tgt;
  logic  a_ok, b_ok;

  dmem_resolve #(.TOP(TOP), .BASE(BASE)) u_res_byte (
    .addr(addr), .mp0(mp0), .mp1(mp1), .tgt(a_tgt), .ok(a_ok)
  );
  dmem_resolve #(.TOP(TOP), .BASE(BASE)) u_res_bit (
    .addr(bit_addr), .mp0(mp0), .mp1(mp1), .tgt(b_tgt), .ok(b_ok)
  );

  dmem_store #(.TOP(TOP), .BASE(BASE)) u_store (
    .clk(clk), .rst_n(srst_n),
    .a_we(wr_en && a_ok), .a_tgt(a_tgt), .a_ok(a_ok), .a_wd(wdata),
    .b_we(bit_en && b_ok), .b_tgt(b_tgt), .b_idx(bit_idx), .b_set(bit_val),
    .flags(hw_flags), .rdata(rdata),
    .mp0(mp0), .mp1(mp1), .acc(acc_q), .stat(stat_q)
  );

  // R3: a window whose pointer aims at a window reads zero
  a_r3_null_window_zero: assert property (@(posedge clk) disable iff (!srst_n)
    ((addr == WIN0 && (mp0 == WIN0 || mp0 == WIN1)) ||
     (addr == WIN1 && (mp1 == WIN0 || mp1 == WIN1))) |-> rdata == 8'h00);

  // R4: reserved gap reads zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (addr > TOP && addr < BASE) |-> rdata == 8'h00);

  // R5: byte write to the accumulator shows up on acc_q
  a_r5_acc_write: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && a_ok && a_tgt == ACC_LOC && !(bit_en && b_ok && b_tgt == ACC_LOC))
    |=> acc_q == $past(wdata));

  // R6: bit operation on the accumulator lands on the chosen bit
  a_r6_acc_bit: assert property (@(posedge clk) disable iff (!srst_n)
    (bit_en && b_ok && b_tgt == ACC_LOC && !(wr_en && a_ok && a_tgt == ACC_LOC))
    |=> acc_q[$past(bit_idx)] == $past(bit_val));

  // R7: protected status bits track the flag input
  a_r7_flags_track: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> stat_q[5:4] == $past(hw_flags));
endmodule

// File: tb/sim_dmem_window.sv
`timescale 1ns/1ps
module sim_dmem_window;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, bit_en, bit_val;
  logic [7:0] addr, wdata, bit_addr;
  logic [2:0] bit_idx;
  logic [1:0] hw_flags;
  logic [7:0] rdata, acc_q, stat_q;

  always #2.5 clk = ~clk;

  dmem_window u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bit_en(bit_en), .bit_addr(bit_addr), .bit_idx(bit_idx),
    .bit_val(bit_val), .hw_flags(hw_flags), .acc_q(acc_q), .stat_q(stat_q)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] m [256];
  bit         known [256];
  logic [7:0] last_rd;

  function automatic logic [7:0] eff(logic [7:0] a);
    if (a == 8'h00) return m[1];
    if (a == 8'h02) return m[3];
    return a;
  endfunction

  function automatic bit is_null(logic [7:0] e);
    return (e == 8'h00) || (e == 8'h02);
  endfunction

  function automatic bit okf(logic [7:0] e);
    return !is_null(e) && (e <= 8'h28 || e >= 8'h40);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit we, logic [7:0] a, logic [7:0] wd,
                     bit be, logic [7:0] ba, logic [2:0] bi, bit bv,
                     logic [1:0] fl);
    logic [7:0] ea, eb, nb, na;
    @(negedge clk);
    wr_en = we; addr = a; wdata = wd;
    bit_en = be; bit_addr = ba; bit_idx = bi; bit_val = bv; hw_flags = fl;
    #0.5;
    chk("R5 acc_q", acc_q, m[8'h05]);
    chk("R7 stat_q", stat_q, m[8'h0A]);
    ea = eff(a);
    last_rd = rdata;
    if (is_null(ea))      chk("R3 null window read", rdata, 8'h00);
    else if (!okf(ea))    chk("R4 reserved read", rdata, 8'h00);
    else if (known[ea])   chk((a == 8'h00 || a == 8'h02) ? "R2 window read" : "R1 read",
                              rdata, m[ea]);
    @(posedge clk);
    eb = eff(ba);
    na = wd;
    if (be && okf(eb)) begin
      nb = (we && okf(ea) && ea == eb) ? wd : m[eb];
      nb[bi] = bv;
      if (we && okf(ea) && ea == eb) na = nb;
    end else nb = 8'h00;
    if (we && okf(ea)) begin m[ea] = na; known[ea] = 1'b1; end
    if (be && okf(eb)) m[eb] = nb;
    m[8'h0A][5:4] = fl;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 8'h00, 3'd0, 1'b0, hw_flags);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    cyc(1'b0, a, 8'h00, 1'b0, 8'h00, 3'd0, 1'b0, hw_flags);
    chk(tag, last_rd, exp);
  endtask

  task automatic bop(logic [7:0] a, logic [2:0] i, bit v);
    cyc(1'b0, 8'h00, 8'h00, 1'b1, a, i, v, hw_flags);
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom % 9)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h01;
      3: return 8'h03;
      4: return 8'h05;
      5: return 8'h0A;
      6: return 8'h29 + 8'($urandom % 23);
      default: return 8'h40 + 8'($urandom % 8);
    endcase
  endfunction

  function automatic logic [7:0] pick_ptr();
    case ($urandom % 6)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h05;
      3: return 8'h0A;
      4: return 8'h30;
      default: return 8'h40 + 8'($urandom % 8);
    endcase
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; bit_en = 0; bit_val = 0;
    addr = 0; wdata = 0; bit_addr = 0; bit_idx = 0; hw_flags = 2'b00;
    for (int i = 0; i < 256; i++) begin
      m[i] = 8'h00;
      known[i] = (i <= 8'h28) || (i >= 8'h29 && i < 8'h40);
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9 reset state
    #1;
    chk("R9 acc after reset", acc_q, 8'h00);
    chk("R9 status after reset", stat_q, 8'h00);
    rd(8'h01, 8'h00, "R9 pointer0 after reset");
    rd(8'h03, 8'h00, "R9 pointer1 after reset");

    // R1 direct RAM
    wr(8'h40, 8'hA5);
    wr(8'hFF, 8'h3C);
    rd(8'h40, 8'hA5, "R1 ram 40");
    rd(8'hFF, 8'h3C, "R1 ram FF");

    // R2 windows
    wr(8'h01, 8'h40);
    rd(8'h00, 8'hA5, "R2 window0 read");
    wr(8'h00, 8'h77);
    rd(8'h40, 8'h77, "R2 window0 write");
    wr(8'h03, 8'hFF);
    rd(8'h02, 8'h3C, "R2 window1 read");

    // R3 pointer aimed at a window
    wr(8'h01, 8'h02);
    rd(8'h00, 8'h00, "R3 window0 via null");
    wr(8'h00, 8'h55);
    rd(8'h02, 8'h3C, "R3 null write left target");
    rd(8'h01, 8'h02, "R3 null write left pointer");
    wr(8'h03, 8'h00);
    rd(8'h02, 8'h00, "R3 window1 via null");

    // R4 reserved gap
    wr(8'h30, 8'h99);
    rd(8'h30, 8'h00, "R4 reserved 30");
    wr(8'h29, 8'h11);
    bop(8'h3F, 3'd0, 1'b1);
    rd(8'h29, 8'h00, "R4 reserved 29");
    rd(8'h3F, 8'h00, "R4 reserved 3F");

    // R5 accumulator / status as memory
    wr(8'h05, 8'h12);
    #1 chk("R5 acc write", acc_q, 8'h12);
    wr(8'h0A, 8'hFF);
    #1 chk("R7 status protected bits", stat_q, 8'hCF);

    // R6 bit operations
    bop(8'h05, 3'd7, 1'b1);
    #1 chk("R6 acc set bit7", acc_q, 8'h92);
    wr(8'h01, 8'h05);
    bop(8'h00, 3'd1, 1'b0);
    #1 chk("R6 acc clear bit1 via window", acc_q, 8'h90);

    // R7 flags
    bop(8'h0A, 3'd4, 1'b1);
    #1 chk("R7 bit op on protected bit", stat_q, 8'hCF);
    hw_flags = 2'b11;
    bop(8'h0A, 3'd0, 1'b0);
    #1 chk("R7 flags loaded", stat_q, 8'hFE);
    hw_flags = 2'b00;

    // R8 same-cycle byte write and bit op
    cyc(1'b1, 8'h45, 8'h00, 1'b1, 8'h45, 3'd3, 1'b1, 2'b00);
    rd(8'h45, 8'h08, "R8 merge set");
    cyc(1'b1, 8'h05, 8'hFF, 1'b1, 8'h00, 3'd0, 1'b0, 2'b00);
    #1 chk("R8 merge through window", acc_q, 8'hFE);

    // random mixes of both ports
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] a, ba, d;
      a  = pick_addr();
      ba = ($urandom % 3 == 0) ? a : pick_addr();
      d  = (a == 8'h01 || a == 8'h03) ? pick_ptr() : 8'($urandom);
      cyc(1'($urandom), a, d, 1'($urandom), ba, 3'($urandom), 1'($urandom),
          2'($urandom));
    end

    finish_run();
  end
endmodule